// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block derives the serial clock of an SPI master from the core clock. A configuration byte holds a prescale field that can be read in one of two ways, picked by a single select input. The legacy reading gives even divisors from 4 to 30. The extended reading builds the divisor as a 4-bit mantissa shifted left by a 3-bit exponent, up to 1920 core clocks per serial-clock period.

The shift engine pulses `start_i` to begin a transfer and `stop_i` to end it. While a transfer runs, the block emits a one-cycle `tick_o` strobe at the end of every half period and toggles `sck_o` on the same edge. The serial clock idles low and begins each transfer with its low half. The divisor is captured from the configuration when the block is idle or when a start arrives. Configuration writes made during a transfer therefore wait for the next start.

Top module: `sclk_prescaler`

## Requirements
- R1: With `enc_ext_i`=0, only `cfg_i[4:0]` is used. A field of 0x10+n with n from 2 to 15 gives a serial-clock period of 2n core clocks, from 4 to 30. Bits 7:5 have no effect.
- R2: With `enc_ext_i`=0, every field value below 0x12 gives a period of 4 core clocks. This includes values with bit 4 clear.
- R3: With `enc_ext_i`=1, the mantissa is `cfg_i[3:0]` and the exponent is {`cfg_i[7]`,`cfg_i[6]`,`cfg_i[4]`} (bit 4 is the exponent LSB). The period is mantissa × 2^exponent, so 0xDF gives 1920.
- R4: With `enc_ext_i`=1, a mantissa of 0 or 1 gives a period of 2 whatever the exponent, and `cfg_i[5]` has no effect.
- R5: `enc_ext_i` alone picks the reading. For example, 0x0A gives 4 with `enc_ext_i`=0 and 10 with `enc_ext_i`=1.
- R6: While running, `tick_o` is high for exactly one cycle at each half-period boundary, and `sck_o` toggles on that same edge.
- R7: A period d is split into a low half of floor(d/2) cycles followed by a high half of d−floor(d/2) cycles. The first rise of `sck_o` comes floor(d/2) cycles after the edge that samples `start_i`.
- R8: `stop_i` makes `sck_o` and `tick_o` low from the next edge on, with no further ticks while idle. `stop_i` wins over a simultaneous `start_i`.
- R9: Changes to `cfg_i` or `enc_ext_i` during a transfer do not change the running period. A `start_i` during a transfer restarts it with the current configuration.
- R10: After reset, `sck_o` and `tick_o` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_i | input | 8 | Configuration byte holding the prescale field |
| enc_ext_i | input | 1 | 0 selects the legacy reading, 1 selects the extended reading |
| start_i | input | 1 | Begin (or restart) a transfer |
| stop_i | input | 1 | End the transfer |
| tick_o | output | 1 | One-cycle strobe at each half-period boundary |
| sck_o | output | 1 | Divided serial clock, idle low |

## Verification
Both outputs are registered. A start sampled on edge E0 therefore shows its first tick and rising `sck_o` after edge E(floor(d/2)). The following edges come after another d−floor(d/2) cycles, then another floor(d/2), and so on. A stop shows after the very next edge. The bench drives inputs 1 ns after a rising edge. It measures half lengths by counting rising edges and reading `tick_o` 1 ns after each one. At every falling edge, it compares both outputs with a behavioural model that advances on the same rising edges. Each measured half is checked against a period computed by arithmetic written separately from the RTL.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;

  localparam int unsigned PSC_CFG_W = 8;
  localparam int unsigned PSC_DIV_W = 11;

  typedef enum logic {
    ENC_LEGACY   = 1'b0,
    ENC_EXTENDED = 1'b1
  } psc_enc_e;

  localparam logic [PSC_CFG_W-1:0] LEGACY_MASK = 8'h1F;
  localparam logic [PSC_CFG_W-1:0] EXT_MASK    = 8'hDF;

  // Legacy: bit4 set with n=bits[3:0] gives 2n; everything under 4 clamps to 4.
  function automatic logic [PSC_DIV_W-1:0] legacy_div(input logic [PSC_CFG_W-1:0] f);
    logic [3:0] n;
    n = f[3:0];
    if (!f[4] || n < 4'd2) return PSC_DIV_W'(4);
    return PSC_DIV_W'({n, 1'b0});
  endfunction

  // Extended: mantissa in bits[3:0], exponent split over bits 7:6 and 4.
  function automatic logic [PSC_DIV_W-1:0] ext_div(input logic [PSC_CFG_W-1:0] f);
    logic [3:0] m;
    logic [2:0] e;
    m = f[3:0];
    e = {f[7:6], f[4]};
    if (m < 4'd2) return PSC_DIV_W'(2);
    return PSC_DIV_W'(m) << e;
  endfunction

  function automatic logic [PSC_DIV_W-1:0] low_half(input logic [PSC_DIV_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [PSC_DIV_W-1:0] high_half(input logic [PSC_DIV_W-1:0] d);
    return d - (d >> 1);
  endfunction

endpackage

// File: rtl/psc_decode.sv
module psc_decode
  import spi_psc_pkg::*;
#(
  parameter int unsigned CFG_W = PSC_CFG_W,
  parameter int unsigned DIV_W = PSC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             enc_ext_i,
  output logic [DIV_W-1:0] div_o
);

  psc_enc_e        enc;
  logic [CFG_W-1:0] field;
  logic [DIV_W-1:0] leg_div;
  logic [DIV_W-1:0] xt_div;

  always_comb begin
    enc     = psc_enc_e'(enc_ext_i);
    field   = cfg_i & ((enc == ENC_EXTENDED) ? EXT_MASK : LEGACY_MASK);
    leg_div = DIV_W'(legacy_div(field));
    xt_div  = DIV_W'(ext_div(field));
    div_o   = (enc == ENC_EXTENDED) ? xt_div : leg_div;
  end

  // R1/R2: legacy output is always an even value within 4..30
  assert_legacy_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enc_ext_i |-> (!div_o[0] && div_o >= DIV_W'(4) && div_o <= DIV_W'(30)));

  // R3/R4: extended output never stalls and never exceeds the top divisor
  assert_ext_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_ext_i |-> (div_o >= DIV_W'(2) && div_o <= DIV_W'(1920)));

endmodule

// File: rtl/psc_div_hold.sv
module psc_div_hold #(
  parameter int unsigned DIV_W = spi_psc_pkg::PSC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] div_o
);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     div_o <= DIV_W'(4);
    else if (load_i) div_o <= div_i;
  end

endmodule

// File: rtl/psc_half_split.sv
module psc_half_split
  import spi_psc_pkg::*;
#(
  parameter int unsigned DIV_W = PSC_DIV_W
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] lo_len_o,
  output logic [DIV_W-1:0] hi_len_o
);

  always_comb begin
    lo_len_o = DIV_W'(low_half(PSC_DIV_W'(div_i)));
    hi_len_o = DIV_W'(high_half(PSC_DIV_W'(div_i)));
  end

endmodule

// File: rtl/psc_phase_ctr.sv
module psc_phase_ctr #(
  parameter int unsigned DIV_W = spi_psc_pkg::PSC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] lo_len_i,
  input  logic [DIV_W-1:0] hi_len_i,
  output logic             running_o,
  output logic             tick_o,
  output logic             sck_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_len;
  logic             half_done;

  always_comb begin
    half_len  = sck_o ? hi_len_i : lo_len_i;
    half_done = running_o && (cnt_q == half_len - DIV_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      running_o <= 1'b0;
      cnt_q     <= '0;
      sck_o     <= 1'b0;
      tick_o    <= 1'b0;
    end else if (stop_i) begin
      running_o <= 1'b0;
      cnt_q     <= '0;
      sck_o     <= 1'b0;
      tick_o    <= 1'b0;
    end else if (start_i) begin
      running_o <= 1'b1;
      cnt_q     <= '0;
      sck_o     <= 1'b0;
      tick_o    <= 1'b0;
    end else if (half_done) begin
      cnt_q  <= '0;
      sck_o  <= ~sck_o;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= running_o ? cnt_q + DIV_W'(1) : '0;
      tick_o <= 1'b0;
    end
  end

  // R6: a tick always marks a change of the serial clock level
  assert_tick_toggles_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sck_o != $past(sck_o)));

  // R7: the half counter never passes the length of the current half
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |-> (cnt_q < half_len));

  // R7: a start (without stop) opens the low half from a cleared count
  assert_start_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (running_o && !sck_o && cnt_q == '0));

  // R8: stop silences both outputs at the next edge
  assert_stop_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!running_o && !sck_o && !tick_o));

  // R8: no tick while idle
  assert_idle_no_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !$past(running_o)) |-> !tick_o);

endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import spi_psc_pkg::*;
#(
  parameter int unsigned CFG_W = PSC_CFG_W,
  parameter int unsigned DIV_W = PSC_DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             enc_ext_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             tick_o,
  output logic             sck_o
);

  logic [DIV_W-1:0] div_now;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lo_len;
  logic [DIV_W-1:0] hi_len;
  logic             running;
  logic             hold_load;

  assign hold_load = !running || start_i;

  psc_decode #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg_i),
    .enc_ext_i (enc_ext_i),
    .div_o     (div_now)
  );

  psc_div_hold #(.DIV_W(DIV_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (hold_load),
    .div_i  (div_now),
    .div_o  (div_q)
  );

  psc_half_split #(.DIV_W(DIV_W)) u_split (
    .div_i    (div_q),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  psc_phase_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .lo_len_i  (lo_len),
    .hi_len_i  (hi_len),
    .running_o (running),
    .tick_o    (tick_o),
    .sck_o     (sck_o)
  );

  // R9: the captured divisor is frozen for the length of a transfer
  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && !start_i) |=> $stable(div_q));

  // R7: the two halves always add back up to the captured divisor
  assert_halves_sum_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_len + hi_len == div_q) && (hi_len >= lo_len));

  // R10: leaving reset the block is idle with a low clock
  assert_reset_idle_R10: assert property (@(posedge clk_i)
    !$past(rst_ni) |-> (!running && !sck_o && !tick_o));

endmodule

// File: tb/tb_sclk_prescaler.sv
`timescale 1ns/1ps
module tb_sclk_prescaler;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cfg_i = 8'h00;
  logic       enc_ext_i = 1'b0;
  logic       start_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       tick_o;
  logic       sck_o;

  int checks = 0;
  int fails = 0;
  string cur_tag = "R10";

  always #2.5 clk_i = ~clk_i;

  sclk_prescaler dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .enc_ext_i(enc_ext_i),
    .start_i(start_i), .stop_i(stop_i), .tick_o(tick_o), .sck_o(sck_o)
  );

  // Expected period from the requirement text (R1..R5)
  function automatic int want_period(input int cfg, input bit ext);
    int v, m, e;
    if (!ext) begin
      v = cfg % 32;
      if (v < 18) return 4;
      return 2 * (v - 16);
    end
    m = cfg % 16;
    e = ((cfg / 64) % 4) * 2 + ((cfg / 16) % 2);
    if (m < 2) return 2;
    return m * (2 ** e);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference, advanced on rising edges
  bit m_run, m_sck, m_tick;
  int m_cnt, m_div;
  always @(posedge clk_i) begin
    int half;
    if (!rst_ni) begin
      m_run = 0; m_sck = 0; m_tick = 0; m_cnt = 0;
    end else begin
      half = m_sck ? (m_div - m_div / 2) : (m_div / 2);
      if (!m_run || start_i) m_div = want_period(cfg_i, enc_ext_i);
      if (stop_i) begin
        m_run = 0; m_sck = 0; m_tick = 0; m_cnt = 0;
      end else if (start_i) begin
        m_run = 1; m_sck = 0; m_tick = 0; m_cnt = 0;
      end else if (m_run) begin
        if (m_cnt == half - 1) begin
          m_cnt = 0; m_sck = !m_sck; m_tick = 1;
        end else begin
          m_cnt++; m_tick = 0;
        end
      end else m_tick = 0;
    end
  end

  always @(negedge clk_i) begin
    check(sck_o == m_sck, cur_tag, "model sck", sck_o, m_sck);
    check(tick_o == m_tick, cur_tag, "model tick", tick_o, m_tick);
  end

  // Edges from the current point until tick_o is seen high
  task automatic count_to_tick(output int n);
    n = 0;
    do begin
      @(posedge clk_i); #1; n++;
    end while (!tick_o && n < 5000);
  endtask

  task automatic pulse_start();
    start_i = 1; @(posedge clk_i); #1; start_i = 0;
  endtask

  task automatic pulse_stop();
    stop_i = 1; @(posedge clk_i); #1; stop_i = 0;
  endtask

  task automatic measure(input int cfg, input bit ext, input string tag);
    int d, n;
    d = want_period(cfg, ext);
    cur_tag = tag;
    cfg_i = cfg[7:0]; enc_ext_i = ext;
    pulse_start();
    count_to_tick(n);
    check(n == d / 2, tag, "low half", n, d / 2);
    check(sck_o == 1'b1, tag, "sck after first tick", sck_o, 1);
    count_to_tick(n);
    check(n == d - d / 2, tag, "high half", n, d - d / 2);
    count_to_tick(n);
    check(n == d / 2, tag, "second low half", n, d / 2);
    pulse_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(posedge clk_i);
    #1;
    check(sck_o == 0 && tick_o == 0, "R10", "reset outputs", {sck_o, tick_o}, 0);
    rst_ni = 1;
    repeat (3) @(posedge clk_i); #1;
    check(sck_o == 0 && tick_o == 0, "R10", "idle after reset", {sck_o, tick_o}, 0);

    measure(8'h1F, 0, "R1");
    measure(8'h13, 0, "R1");
    measure(8'hF7, 0, "R1");   // bits 7:5 set, field 0x17 -> 14
    measure(8'h10, 0, "R2");
    measure(8'h11, 0, "R2");
    measure(8'h05, 0, "R2");
    measure(8'hDF, 1, "R3");
    measure(8'h13, 1, "R3");
    measure(8'h82, 1, "R3");
    measure(8'h05, 1, "R7");   // odd: 2 low, 3 high
    measure(8'h41, 1, "R4");
    measure(8'h90, 1, "R4");
    measure(8'h23, 1, "R4");   // bit 5 ignored -> 3
    measure(8'h0A, 0, "R5");
    measure(8'h0A, 1, "R5");

    // R9: configuration change during a transfer is held off
    cur_tag = "R9";
    cfg_i = 8'h14; enc_ext_i = 0;
    pulse_start();
    count_to_tick(n);
    check(n == 4, "R9", "low half before change", n, 4);
    cfg_i = 8'h1F; enc_ext_i = 1;
    count_to_tick(n);
    check(n == 4, "R9", "high half after change", n, 4);
    count_to_tick(n);
    check(n == 4, "R9", "low half after change", n, 4);
    cfg_i = 8'h1F; enc_ext_i = 0;
    pulse_start();
    check(sck_o == 0, "R9", "sck low on restart", sck_o, 0);
    count_to_tick(n);
    check(n == 15, "R9", "restart picks new period", n, 15);
    pulse_stop();

    // R8: stop mid-run and stay quiet; stop beats start
    cur_tag = "R8";
    cfg_i = 8'h13; enc_ext_i = 0;
    pulse_start();
    repeat (4) @(posedge clk_i); #1;
    pulse_stop();
    for (int i = 0; i < 40; i++) begin
      check(sck_o == 0 && tick_o == 0, "R8", "idle after stop", {sck_o, tick_o}, 0);
      @(posedge clk_i); #1;
    end
    start_i = 1; stop_i = 1;
    @(posedge clk_i); #1;
    start_i = 0; stop_i = 0;
    for (int i = 0; i < 20; i++) begin
      check(sck_o == 0 && tick_o == 0, "R8", "stop wins over start", {sck_o, tick_o}, 0);
      @(posedge clk_i); #1;
    end

    // R6: one-cycle ticks on a fast setting
    cur_tag = "R6";
    cfg_i = 8'h00; enc_ext_i = 1;
    pulse_start();
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_i); #1;
      check(tick_o == 1, "R6", "tick every cycle at period 2", tick_o, 1);
    end
    pulse_stop();

    repeat (3) @(posedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule